// File: doc/BRIEF.md
# NAND Defect Scan and Spare-Block Redirector

This block runs once after power-up to find blocks that were shipped unusable. For every physical block it asks the flash sequencer to read a marker byte from each of the first few pages. Any byte other than the erased pattern marks the block defective. Defective blocks are recorded in a defect map. A fixed group of blocks at the top of the address range is held back as replacements, and each defective user block is steered to one of them.

After the scan, the rest of the controller presents a physical block number and receives, one clock later, the block it should really access. It also receives a flag that says the block is defective and has no replacement. When an erase fails at run time, the controller retires the block. The block then takes the next free replacement, as long as one is left. The pool is sized to roughly two percent of the device and is never refilled, so an exhaustion flag tells the controller when no further redirection is possible.

Top module: `nand_defect_remap`

## Requirements
- R1: While reset is applied and until a scan is started, `rd_req`, `scan_done` and `pool_exhausted` are all 0.
- R2: After a one-cycle `scan_start`, the block issues one single-cycle `rd_req` per marker. It starts at block NUM_BLOCKS-1 and counts down to block 0. Within each block it reads pages 0 to MARK_PAGES-1 in ascending order, and MARK_PAGES defaults to 2. It issues the next request only after `marker_valid` has returned the previous byte. `scan_done` rises after block 0 has been checked and then stays high.
- R3: A marker byte of 8'hFF is good. Any other value in any checked page marks the block defective, and a defect entry is never cleared.
- R4: The spare pool is the SPARES highest blocks, where SPARES = ceil(2 % of NUM_BLOCKS) with a minimum of 1, so the default of 256 blocks gives 6 spares at 250 to 255. Spare slot k is block NUM_BLOCKS-SPARES+k. A spare found defective during the scan is never handed out, and looking it up returns its own index with `lk_unusable` = 1.
- R5: Each defective user block takes the lowest-numbered free good slot. Blocks are served in scan order, so higher block numbers are served first.
- R6: The cycle after `lk_block` is applied, `lk_index` holds the replacement block for a redirected user block and the block's own index otherwise. `lk_unusable` is 1 only for a defective block that has no replacement.
- R7: Once `scan_done` is high, a `retire_valid` pulse on a user block marks that block defective and gives it the lowest free slot.
- R8: A retire is ignored in three cases: the block is already redirected, the index lies in the spare range, or the retire arrives before `scan_done`. An ignored retire consumes no spare and changes no lookup result.
- R9: `pool_exhausted` is 1 when `scan_done` is high and no free good spare remains. A user block retired in that state keeps its own index and reads back `lk_unusable` = 1.
- R10: When a retire and a lookup of the same block fall in the same cycle, that lookup returns the mapping from before the retire. The next lookup returns the new mapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| scan_start | input | 1 | One-cycle pulse that begins the defect scan |
| rd_req | output | 1 | Marker read request to the flash sequencer |
| rd_block | output | BLK_W | Block of the requested marker |
| rd_page | output | PG_W | Page of the requested marker |
| marker_valid | input | 1 | Returned marker byte is valid this cycle |
| marker_byte | input | 8 | Returned marker byte |
| scan_done | output | 1 | All blocks have been checked |
| retire_valid | input | 1 | Retire a block after a failed erase |
| retire_block | input | BLK_W | Block to retire |
| lk_block | input | BLK_W | Physical block to translate |
| lk_index | output | BLK_W | Block to use, valid one cycle after `lk_block` |
| lk_unusable | output | 1 | Translated block is defective with no replacement |
| pool_exhausted | output | 1 | No free spare left after the scan |

## Verification
A run-time retire and a lookup can hit the same block in the same clock. The table update and the registered lookup both act on that edge. The bench drives `retire_valid` and `lk_block` together at one falling edge. It expects the original index on the next sample and the newly assigned spare on the sample after that. A retire is also injected while the scan is still reading markers, and the bench requires the lookup of that block to be unaffected afterwards.

// File: rtl/bbm_pkg.sv
package bbm_pkg;

  typedef enum logic [2:0] {
    SC_IDLE,
    SC_ISSUE_READ,
    SC_WAIT_DATA,
    SC_CHECK,
    SC_NEXT,
    SC_DONE
  } scan_state_e;

  localparam logic [7:0] ERASED_MARK = 8'hFF;

  // ceil(2% of blocks), never below one spare
  function automatic int spare_pool_size(input int blocks);
    int n;
    n = (blocks * 2 + 99) / 100;
    if (n < 1) n = 1;
    return n;
  endfunction

endpackage

// File: rtl/bbm_scan_ctrl.sv
module bbm_scan_ctrl
  import bbm_pkg::*;
#(
  parameter int NUM_BLOCKS = 256,
  parameter int MARK_PAGES = 2,
  parameter int BLK_W      = 8,
  parameter int PG_W       = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             mark_vld_i,
  input  logic [7:0]       mark_byte_i,
  output logic             rd_req_o,
  output logic [BLK_W-1:0] rd_blk_o,
  output logic [PG_W-1:0]  rd_pg_o,
  output logic             commit_o,
  output logic [BLK_W-1:0] commit_blk_o,
  output logic             commit_bad_o,
  output logic             done_o
);

  localparam logic [BLK_W-1:0] LAST_BLK = BLK_W'(NUM_BLOCKS - 1);
  localparam logic [PG_W-1:0]  LAST_PG  = PG_W'(MARK_PAGES - 1);

  scan_state_e      state_q, state_d;
  logic [BLK_W-1:0] blk_q, blk_d;
  logic [PG_W-1:0]  pg_q, pg_d;
  logic             acc_q, acc_d;
  logic [7:0]       mark_q;
  logic             mark_en;

  always_comb begin
    state_d = state_q;
    blk_d   = blk_q;
    pg_d    = pg_q;
    acc_d   = acc_q;
    mark_en = 1'b0;
    unique case (state_q)
      SC_IDLE: begin
        if (start_i) begin
          state_d = SC_ISSUE_READ;
          blk_d   = LAST_BLK;
          pg_d    = '0;
          acc_d   = 1'b0;
        end
      end
      SC_ISSUE_READ: state_d = SC_WAIT_DATA;
      SC_WAIT_DATA: begin
        if (mark_vld_i) begin
          mark_en = 1'b1;
          state_d = SC_CHECK;
        end
      end
      SC_CHECK: begin
        acc_d = acc_q | (mark_q != ERASED_MARK);
        if (pg_q == LAST_PG) begin
          state_d = SC_NEXT;
        end else begin
          pg_d    = pg_q + 1'b1;
          state_d = SC_ISSUE_READ;
        end
      end
      SC_NEXT: begin
        acc_d = 1'b0;
        pg_d  = '0;
        if (blk_q == '0) begin
          state_d = SC_DONE;
        end else begin
          blk_d   = blk_q - 1'b1;
          state_d = SC_ISSUE_READ;
        end
      end
      SC_DONE: state_d = SC_DONE;
      default: state_d = SC_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SC_IDLE;
      blk_q   <= '0;
      pg_q    <= '0;
      acc_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      blk_q   <= blk_d;
      pg_q    <= pg_d;
      acc_q   <= acc_d;
    end
  end

  always_ff @(posedge clk) begin
    if (mark_en) mark_q <= mark_byte_i;
  end

  assign rd_req_o     = (state_q == SC_ISSUE_READ);
  assign rd_blk_o     = blk_q;
  assign rd_pg_o      = pg_q;
  assign commit_o     = (state_q == SC_NEXT);
  assign commit_blk_o = blk_q;
  assign commit_bad_o = acc_q;
  assign done_o       = (state_q == SC_DONE);

  // R2: requests are single-cycle pulses
  p_req_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_o |=> !rd_req_o);
  // R2: only the marker pages are ever requested
  p_page_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_o |-> (rd_pg_o <= LAST_PG));
  // R2: completion holds once reached
  p_done_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> done_o);

endmodule

// File: rtl/bbm_spare_pool.sv
module bbm_spare_pool #(
  parameter int SPARES = 6,
  parameter int SLOT_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_good_i,
  input  logic [SLOT_W-1:0] set_slot_i,
  input  logic              alloc_req_i,
  output logic              alloc_gnt_o,
  output logic [SLOT_W-1:0] alloc_slot_o,
  output logic              any_free_o
);

  logic [SPARES-1:0] free_q, free_d;
  logic [SLOT_W-1:0] pick;

  // lowest free slot wins
  always_comb begin
    pick = '0;
    for (int i = SPARES - 1; i >= 0; i--) begin
      if (free_q[i]) pick = SLOT_W'(i);
    end
  end

  assign any_free_o   = |free_q;
  assign alloc_gnt_o  = alloc_req_i & any_free_o;
  assign alloc_slot_o = pick;

  always_comb begin
    free_d = free_q;
    if (set_good_i)  free_d[set_slot_i] = 1'b1;
    if (alloc_gnt_o) free_d[pick]       = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) free_q <= '0;
    else        free_q <= free_d;
  end

  // R5: a granted slot is no longer free on the next cycle
  p_slot_consumed_r5: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_gnt_o |=> !free_q[$past(alloc_slot_o)]);
  // R4: marking a spare good and requesting a spare never coincide
  p_set_vs_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
    set_good_i |-> !alloc_req_i);

endmodule

// File: rtl/bbm_remap_table.sv
module bbm_remap_table #(
  parameter int NUM_BLOCKS = 256,
  parameter int SPARES     = 6,
  parameter int BLK_W      = 8,
  parameter int SLOT_W     = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mark_i,
  input  logic [BLK_W-1:0]  mark_blk_i,
  output logic              alloc_req_o,
  input  logic              alloc_gnt_i,
  input  logic [SLOT_W-1:0] alloc_slot_i,
  input  logic [BLK_W-1:0]  lk_blk_i,
  output logic [BLK_W-1:0]  lk_index_o,
  output logic              lk_unusable_o
);

  localparam int               USER_BLOCKS = NUM_BLOCKS - SPARES;
  localparam logic [BLK_W-1:0] SPARE_BASE  = BLK_W'(USER_BLOCKS);

  logic [NUM_BLOCKS-1:0] defect_q, defect_d;
  logic [NUM_BLOCKS-1:0] map_vld_q, map_vld_d;
  logic [SLOT_W-1:0]     map_slot_q [NUM_BLOCKS];
  logic                  map_wr;
  logic                  mark_user;
  logic [BLK_W-1:0]      lk_idx_d;
  logic                  lk_unus_d;

  assign mark_user   = (mark_blk_i < SPARE_BASE);
  assign alloc_req_o = mark_i & mark_user & ~map_vld_q[mark_blk_i];
  assign map_wr      = alloc_req_o & alloc_gnt_i;

  always_comb begin
    defect_d  = defect_q;
    map_vld_d = map_vld_q;
    if (mark_i) defect_d[mark_blk_i]  = 1'b1;
    if (map_wr) map_vld_d[mark_blk_i] = 1'b1;
  end

  always_comb begin
    if (map_vld_q[lk_blk_i]) lk_idx_d = SPARE_BASE + BLK_W'(map_slot_q[lk_blk_i]);
    else                     lk_idx_d = lk_blk_i;
    lk_unus_d = defect_q[lk_blk_i] & ~map_vld_q[lk_blk_i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      defect_q      <= '0;
      map_vld_q     <= '0;
      lk_index_o    <= '0;
      lk_unusable_o <= 1'b0;
    end else begin
      defect_q      <= defect_d;
      map_vld_q     <= map_vld_d;
      lk_index_o    <= lk_idx_d;
      lk_unusable_o <= lk_unus_d;
    end
  end

  always_ff @(posedge clk) begin
    if (map_wr) map_slot_q[mark_blk_i] <= alloc_slot_i;
  end

  // R3: defect entries are never cleared
  p_defect_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(defect_q) & ~defect_q) == '0);
  // R8: a redirection, once made, is never dropped
  p_map_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(map_vld_q) & ~map_vld_q) == '0);

endmodule

// File: rtl/nand_defect_remap.sv
module nand_defect_remap
  import bbm_pkg::*;
#(
  parameter int NUM_BLOCKS = 256,
  parameter int MARK_PAGES = 2,
  parameter int SPARES     = spare_pool_size(NUM_BLOCKS),
  parameter int BLK_W      = $clog2(NUM_BLOCKS),
  parameter int PG_W       = (MARK_PAGES > 1) ? $clog2(MARK_PAGES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scan_start,
  output logic             rd_req,
  output logic [BLK_W-1:0] rd_block,
  output logic [PG_W-1:0]  rd_page,
  input  logic             marker_valid,
  input  logic [7:0]       marker_byte,
  output logic             scan_done,
  input  logic             retire_valid,
  input  logic [BLK_W-1:0] retire_block,
  input  logic [BLK_W-1:0] lk_block,
  output logic [BLK_W-1:0] lk_index,
  output logic             lk_unusable,
  output logic             pool_exhausted
);

  localparam int               SLOT_W     = (SPARES > 1) ? $clog2(SPARES) : 1;
  localparam logic [BLK_W-1:0] SPARE_BASE = BLK_W'(NUM_BLOCKS - SPARES);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic             commit;
  logic [BLK_W-1:0] commit_blk;
  logic             commit_bad;
  logic             retire_ok;
  logic             mark;
  logic [BLK_W-1:0] mark_blk;
  logic             set_good;
  logic [SLOT_W-1:0] set_slot;
  logic             alloc_req, alloc_gnt, any_free;
  logic [SLOT_W-1:0] alloc_slot;

  bbm_scan_ctrl #(
    .NUM_BLOCKS(NUM_BLOCKS), .MARK_PAGES(MARK_PAGES), .BLK_W(BLK_W), .PG_W(PG_W)
  ) u_scan (
    .clk(clk), .rst_n(rst_int_n), .start_i(scan_start),
    .mark_vld_i(marker_valid), .mark_byte_i(marker_byte),
    .rd_req_o(rd_req), .rd_blk_o(rd_block), .rd_pg_o(rd_page),
    .commit_o(commit), .commit_blk_o(commit_blk), .commit_bad_o(commit_bad),
    .done_o(scan_done)
  );

  // scan commits and retires are exclusive: retires wait for scan_done
  assign retire_ok = retire_valid & scan_done & (retire_block < SPARE_BASE);
  assign mark      = (commit & commit_bad) | retire_ok;
  assign mark_blk  = commit ? commit_blk : retire_block;
  assign set_good  = commit & ~commit_bad & (commit_blk >= SPARE_BASE);
  assign set_slot  = SLOT_W'(commit_blk - SPARE_BASE);

  bbm_spare_pool #(.SPARES(SPARES), .SLOT_W(SLOT_W)) u_pool (
    .clk(clk), .rst_n(rst_int_n),
    .set_good_i(set_good), .set_slot_i(set_slot),
    .alloc_req_i(alloc_req), .alloc_gnt_o(alloc_gnt),
    .alloc_slot_o(alloc_slot), .any_free_o(any_free)
  );

  bbm_remap_table #(
    .NUM_BLOCKS(NUM_BLOCKS), .SPARES(SPARES), .BLK_W(BLK_W), .SLOT_W(SLOT_W)
  ) u_table (
    .clk(clk), .rst_n(rst_int_n),
    .mark_i(mark), .mark_blk_i(mark_blk),
    .alloc_req_o(alloc_req), .alloc_gnt_i(alloc_gnt), .alloc_slot_i(alloc_slot),
    .lk_blk_i(lk_block), .lk_index_o(lk_index), .lk_unusable_o(lk_unusable)
  );

  assign pool_exhausted = scan_done & ~any_free;

  logic past_ok_q;
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) past_ok_q <= 1'b0;
    else            past_ok_q <= 1'b1;
  end

  // R8: a retire before the scan ends never takes a spare
  p_early_retire_r8: assert property (@(posedge clk) disable iff (!rst_int_n)
    (retire_valid && !scan_done) |-> !alloc_gnt);
  // R6: a redirected result always points into the spare range and is usable
  p_lookup_target_r6: assert property (@(posedge clk) disable iff (!rst_int_n)
    (past_ok_q && (lk_index != $past(lk_block))) |-> ((lk_index >= SPARE_BASE) && !lk_unusable));
  // R9: once exhausted, the flag stays set
  p_exhaust_sticky_r9: assert property (@(posedge clk) disable iff (!rst_int_n)
    pool_exhausted |=> pool_exhausted);

endmodule

// File: tb/sim_nand_defect_remap.sv
module sim_nand_defect_remap;

  localparam int NB    = 256;
  localparam int PAGES = 2;
  localparam int SP    = 6;
  localparam int BASE  = NB - SP;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       scan_start, marker_valid, retire_valid;
  logic [7:0] marker_byte, retire_block, lk_block;
  logic       rd_req, scan_done, lk_unusable, pool_exhausted;
  logic [7:0] rd_block, lk_index;
  logic [0:0] rd_page;

  always #10 clk = ~clk;  // 50 MHz

  nand_defect_remap u0 (
    .clk(clk), .rst_n(rst_n), .scan_start(scan_start),
    .rd_req(rd_req), .rd_block(rd_block), .rd_page(rd_page),
    .marker_valid(marker_valid), .marker_byte(marker_byte),
    .scan_done(scan_done), .retire_valid(retire_valid), .retire_block(retire_block),
    .lk_block(lk_block), .lk_index(lk_index), .lk_unusable(lk_unusable),
    .pool_exhausted(pool_exhausted)
  );

  int n_checks = 0;
  int n_fail   = 0;
  int bad_page [NB];
  int bad_byte [NB];
  int exp_map  [NB];
  bit exp_bad  [NB];
  bit free_m   [SP];
  bit model_done = 1'b0;
  int n_req = 0;
  int exp_b = NB - 1;
  int exp_p = 0;

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int take_slot();
    for (int i = 0; i < SP; i++) begin
      if (free_m[i]) begin
        free_m[i] = 1'b0;
        return i;
      end
    end
    return -1;
  endfunction

  function automatic int exp_index(input int b);
    return (exp_map[b] >= 0) ? exp_map[b] : b;
  endfunction

  function automatic int exp_unus(input int b);
    return (exp_bad[b] && exp_map[b] < 0) ? 1 : 0;
  endfunction

  function automatic int any_free_m();
    for (int i = 0; i < SP; i++) if (free_m[i]) return 1;
    return 0;
  endfunction

  // model of the scan outcome, built from R3/R4/R5
  task automatic build_model();
    for (int b = 0; b < NB; b++) begin
      exp_map[b] = -1;
      exp_bad[b] = (bad_page[b] >= 0);
    end
    for (int b = NB - 1; b >= BASE; b--) free_m[b - BASE] = (bad_page[b] < 0);
    for (int b = BASE - 1; b >= 0; b--) begin
      if (exp_bad[b]) begin
        int s;
        s = take_slot();
        if (s >= 0) exp_map[b] = BASE + s;
      end
    end
  endtask

  task automatic model_retire(input int b);
    if (!model_done || b >= BASE) return;
    exp_bad[b] = 1'b1;
    if (exp_map[b] < 0) begin
      int s;
      s = take_slot();
      if (s >= 0) exp_map[b] = BASE + s;
    end
  endtask

  task automatic do_retire(input int b);
    @(negedge clk);
    retire_valid = 1'b1;
    retire_block = 8'(b);
    @(negedge clk);
    retire_valid = 1'b0;
    model_retire(b);
  endtask

  task automatic look(input string req, input int b);
    @(negedge clk);
    lk_block = 8'(b);
    @(negedge clk);
    chk(req, int'(lk_index), exp_index(b));
    chk(req, int'(lk_unusable), exp_unus(b));
  endtask

  // flash marker responder (R2, R3)
  initial begin
    forever begin
      @(negedge clk);
      if (rd_req) begin
        int b, p, lat;
        b = int'(rd_block);
        p = int'(rd_page);
        n_req++;
        chk("R2 read block order", b, exp_b);
        chk("R2 read page order", p, exp_p);
        exp_p++;
        if (exp_p == PAGES) begin
          exp_p = 0;
          exp_b--;
        end
        lat = $urandom_range(3, 1);
        repeat (lat) @(negedge clk);
        marker_byte  = (bad_page[b] == p) ? 8'(bad_byte[b]) : 8'hFF;
        marker_valid = 1'b1;
        @(negedge clk);
        marker_valid = 1'b0;
      end
    end
  end

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL R2 watchdog: scan_done=%0d expected 1", scan_done);
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    int rnd, wait_cnt;
    process::self().srandom(32'd1337);
    rst_n = 1'b0;
    scan_start = 1'b0;
    marker_valid = 1'b0;
    marker_byte = 8'hFF;
    retire_valid = 1'b0;
    retire_block = '0;
    lk_block = '0;

    // factory defect pattern: two directed, one random user block
    for (int b = 0; b < NB; b++) begin
      bad_page[b] = -1;
      bad_byte[b] = $urandom_range(254, 0);
    end
    bad_page[40]  = 1;   // marker only on the second page
    bad_page[251] = 0;   // defective spare, slot 1
    bad_byte[251] = 8'hFE;
    bad_byte[40]  = 8'h00;
    rnd = $urandom_range(198, 101);
    bad_page[rnd] = $urandom_range(1, 0);
    build_model();

    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 rd_req in reset", int'(rd_req), 0);
    chk("R1 scan_done in reset", int'(scan_done), 0);
    chk("R1 pool_exhausted in reset", int'(pool_exhausted), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R1 idle rd_req before start", int'(rd_req), 0);
    chk("R1 idle scan_done before start", int'(scan_done), 0);

    // R2: start scan
    @(negedge clk);
    scan_start = 1'b1;
    @(negedge clk);
    scan_start = 1'b0;

    // R8: retire during scan is ignored
    repeat (60) @(negedge clk);
    do_retire(10);

    wait_cnt = 0;
    while (!scan_done && wait_cnt < 100000) begin
      @(negedge clk);
      wait_cnt++;
    end
    model_done = 1'b1;
    chk("R2 scan_done reached", int'(scan_done), 1);
    chk("R2 request count", n_req, NB * PAGES);
    repeat (4) @(negedge clk);
    chk("R2 no request after done", int'(rd_req), 0);
    chk("R2 scan_done holds", int'(scan_done), 1);

    // R3/R5/R4: scan results
    look("R3 R5 bad block 40 (page 1 marker)", 40);
    look("R3 R5 random bad block", rnd);
    look("R4 defective spare 251", 251);
    look("R4 good spare 250 own index", 250);
    look("R8 retire during scan ignored", 10);
    chk("R9 pool not exhausted after scan", int'(pool_exhausted), any_free_m() ? 0 : 1);

    // R6: random lookups
    for (int i = 0; i < 60; i++) look("R6 random lookup", $urandom_range(NB - 1, 0));

    // R8: retire of a spare index ignored
    do_retire(253);
    look("R8 spare retire ignored", 253);

    // R7: first run-time retire
    do_retire(7);
    look("R7 retire gets lowest free spare", 7);

    // R8: second retire of same block ignored
    do_retire(7);
    look("R8 repeated retire ignored", 7);

    // R10: retire and lookup of same block in the same cycle
    @(negedge clk);
    lk_block = 8'd99;
    retire_valid = 1'b1;
    retire_block = 8'd99;
    @(negedge clk);
    retire_valid = 1'b0;
    chk("R10 same-cycle lookup sees old index", int'(lk_index), 99);
    chk("R10 same-cycle lookup sees old usable", int'(lk_unusable), 0);
    model_retire(99);
    @(negedge clk);
    chk("R10 following lookup sees spare", int'(lk_index), exp_index(99));

    // R7/R9: drain the pool
    do_retire(200);
    look("R7 retire takes last spare", 200);
    chk("R9 pool_exhausted after last spare", int'(pool_exhausted), 1);

    do_retire(33);
    look("R9 retire with empty pool unusable", 33);
    do_retire(40);
    look("R8 mapped block retire ignored", 40);
    chk("R9 pool_exhausted holds", int'(pool_exhausted), 1);

    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule